// File: doc/BRIEF.md
# Serial Flash Write-Permission Front End

This block sits on the device side of a serial flash interface. It watches chip select (active low), serial clock and serial data in, and brings all three into the local clock domain through a synchronizer. It shifts the command byte in most significant bit first on each rising serial clock edge while chip select is low. It acts on the command only when chip select returns high. The serial clock may idle low or idle high between commands, and the block handles both.

Two permission states are kept. The write latch is set by opcode 0x06. It gates every modifying operation and is cleared by reset or by a completion pulse from the program, erase or status-write engines. The volatile-write flag is armed by opcode 0x50 and does not touch the latch. It unlocks only the next status-register write (opcode 0x01), and routes that write to the volatile status copy so that no non-volatile write cycle is started. A completed status-write frame produces one start pulse, either toward the volatile copy or toward the non-volatile cells. The data output driver stays disabled for these commands.

Top module: `flash_wren_ctrl`

## Requirements
- R1: After reset, `wel_o`, `allow_modify_o`, `vol_wr_en_o`, `sr_wr_vol_o` and `sr_wr_nv_o` are 0.
- R2: A frame of exactly 8 serial clock rising edges carrying 0x06, most significant bit first, sets `wel_o` to 1. The change happens only after chip select returns high, not while it is still low.
- R3: An 8-clock frame carrying 0x50 sets `vol_wr_en_o` to 1 and leaves `wel_o` unchanged, whether it was 0 or 1.
- R4: Frames are accepted with the serial clock idling low (mode 0) and with it idling high (mode 3) at chip select edges.
- R5: A frame is ignored when its clock count is invalid. A valid count is 8 for any opcode, or, for 0x01 only, a multiple of 8 from 16 to 8*(1+SR_DATA_MAX). An ignored frame changes neither `wel_o` nor `vol_wr_en_o` and produces no pulse. Serial clock edges while chip select is high are also ignored.
- R6: A one-cycle pulse on `wel_clr_i` clears `wel_o` in the next cycle. If a 0x06 frame completes in the same cycle, the set wins.
- R7: A valid status-write frame (0x01 with data bytes) completed while `vol_wr_en_o` is 1 produces exactly one `sr_wr_vol_o` pulse, no `sr_wr_nv_o` pulse, and clears `vol_wr_en_o`.
- R8: A valid status-write frame completed while `vol_wr_en_o` is 0 produces one `sr_wr_nv_o` pulse if `wel_o` is 1. It produces no pulse at all if `wel_o` is 0.
- R9: Any other completed 8-clock command (any opcode except 0x50) clears `vol_wr_en_o`.
- R10: `allow_modify_o` always equals `wel_o`, and `spi_do_oe_o` stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_sdi | input | 1 | Serial data in |
| wel_clr_i | input | 1 | Completion pulse from program, erase or status-write logic that clears the latch |
| wel_o | output | 1 | Write latch state |
| allow_modify_o | output | 1 | Permission gate for program, erase and status-write logic |
| vol_wr_en_o | output | 1 | Volatile status-write permission flag |
| sr_wr_vol_o | output | 1 | One-cycle start of a status write into the volatile copy |
| sr_wr_nv_o | output | 1 | One-cycle start of a status write into the non-volatile cells |
| spi_do_oe_o | output | 1 | Output enable for the data-out driver, held low |

## Verification
The bench builds the block with SYNC_STAGES=3 and SR_DATA_MAX=2. The deeper synchronizer lengthens the delay from a chip select rise to a state change, so the checks taken while chip select is still low really do fall before the decode. With two data bytes allowed, both the 16-clock and the 24-clock status-write frames are valid, and a 32-clock frame lies just past the limit and must be ignored. Frames are sent in both clock polarities, with short and long bit counts around each valid length.

// File: rtl/flash_wren_pkg.sv
package flash_wren_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_WREN,
      CMD_VWREN,
      CMD_SRWR,
      CMD_OTHER
   } fw_cmd_e;

endpackage

// File: rtl/fw_sync.sv
module fw_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fw_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= RST_VAL;
            else        stage_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/fw_shifter.sv
module fw_shifter #(
   parameter int OPC_W   = 8,
   parameter int CNT_SAT = 25,
   localparam int CNT_W  = $clog2(CNT_SAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_s,
   input  logic             sclk_s,
   input  logic             sdi_s,
   output logic             frame_end_o,
   output logic [OPC_W-1:0] opc_o,
   output logic [CNT_W-1:0] cnt_o
);

   if (OPC_W < 2) begin : g_bad_opc
      $error("fw_shifter: OPC_W must be at least 2");
   end

   logic cs_q, sclk_q;
   logic cs_fall, cs_rise, sclk_rise;
   logic [OPC_W-1:0] opc_q;
   logic [CNT_W-1:0] cnt_q;

   assign cs_fall   = cs_q & ~cs_n_s;
   assign cs_rise   = ~cs_q & cs_n_s;
   assign sclk_rise = sclk_s & ~sclk_q & ~cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs_n_s;
         sclk_q <= sclk_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         opc_q <= '0;
      end else if (cs_fall) begin
         cnt_q <= '0;
         opc_q <= '0;
      end else if (sclk_rise) begin
         if (int'(cnt_q) < CNT_SAT) cnt_q <= cnt_q + 1'b1;
         if (int'(cnt_q) < OPC_W)   opc_q <= {opc_q[OPC_W-2:0], sdi_s};
      end
   end

   assign frame_end_o = cs_rise;
   assign opc_o       = opc_q;
   assign cnt_o       = cnt_q;

   AST_IDLE_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && cs_q && sclk_s && !sclk_q) |=> ($stable(cnt_q) && $stable(opc_q))); // R5

endmodule

// File: rtl/fw_decode.sv
module fw_decode
   import flash_wren_pkg::*;
#(
   parameter int OPC_W    = 8,
   parameter int MAX_BITS = 24,
   parameter int CNT_W    = 5,
   parameter logic [OPC_W-1:0] OPC_WREN  = 8'h06,
   parameter logic [OPC_W-1:0] OPC_VWREN = 8'h50,
   parameter logic [OPC_W-1:0] OPC_SRWR  = 8'h01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end_i,
   input  logic [OPC_W-1:0] opc_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             wel_clr_i,
   output logic             wel_o,
   output logic             vflag_o,
   output logic             sr_vol_o,
   output logic             sr_nv_o
);

   fw_cmd_e cmd;
   logic    len_one, len_sr;
   logic    wel_q, vflag_q, sr_vol_q, sr_nv_q;

   assign len_one = (int'(cnt_i) == OPC_W);
   assign len_sr  = (int'(cnt_i) >= 2 * OPC_W) && (int'(cnt_i) <= MAX_BITS)
                    && ((int'(cnt_i) % OPC_W) == 0);

   always_comb begin
      cmd = CMD_NONE;
      if (frame_end_i) begin
         if (opc_i == OPC_SRWR && len_sr)  cmd = CMD_SRWR;
         else if (len_one) begin
            if (opc_i == OPC_WREN)         cmd = CMD_WREN;
            else if (opc_i == OPC_VWREN)   cmd = CMD_VWREN;
            else                           cmd = CMD_OTHER;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q    <= 1'b0;
         vflag_q  <= 1'b0;
         sr_vol_q <= 1'b0;
         sr_nv_q  <= 1'b0;
      end else begin
         sr_vol_q <= 1'b0;
         sr_nv_q  <= 1'b0;
         if (wel_clr_i) wel_q <= 1'b0;
         case (cmd)
            CMD_WREN: begin
               wel_q   <= 1'b1;
               vflag_q <= 1'b0;
            end
            CMD_VWREN: vflag_q <= 1'b1;
            CMD_SRWR: begin
               sr_vol_q <= vflag_q;
               sr_nv_q  <= ~vflag_q & wel_q;
               vflag_q  <= 1'b0;
            end
            CMD_OTHER: vflag_q <= 1'b0;
            default: ;
         endcase
      end
   end

   assign wel_o    = wel_q;
   assign vflag_o  = vflag_q;
   assign sr_vol_o = sr_vol_q;
   assign sr_nv_o  = sr_nv_q;

   AST_WREN_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WREN) |=> wel_q); // R2
   AST_VWREN_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_VWREN && !wel_clr_i) |=> ($stable(wel_q) && vflag_q)); // R3
   AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (wel_clr_i && cmd != CMD_WREN) |=> !wel_q); // R6
   AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sr_vol_q, sr_nv_q})); // R7
   AST_SR_CONSUMES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_SRWR) |=> (!vflag_q && (sr_vol_q == $past(vflag_q)))); // R7
   AST_NV_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      sr_nv_q |-> $past(wel_q)); // R8
   AST_OTHER_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_OTHER) |=> !vflag_q); // R9
   AST_IGNORED_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end_i && cmd == CMD_NONE && !wel_clr_i)
         |=> ($stable(wel_q) && $stable(vflag_q) && !sr_vol_q && !sr_nv_q)); // R5

endmodule

// File: rtl/flash_wren_ctrl.sv
module flash_wren_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int OPC_W       = 8,
   parameter int SR_DATA_MAX = 2,
   parameter logic [OPC_W-1:0] OPC_WREN  = 8'h06,
   parameter logic [OPC_W-1:0] OPC_VWREN = 8'h50,
   parameter logic [OPC_W-1:0] OPC_SRWR  = 8'h01
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sclk,
   input  logic spi_sdi,
   input  logic wel_clr_i,
   output logic wel_o,
   output logic allow_modify_o,
   output logic vol_wr_en_o,
   output logic sr_wr_vol_o,
   output logic sr_wr_nv_o,
   output logic spi_do_oe_o
);

   localparam int MAX_BITS = OPC_W * (1 + SR_DATA_MAX);
   localparam int CNT_SAT  = MAX_BITS + 1;
   localparam int CNT_W    = $clog2(CNT_SAT + 1);

   if (SR_DATA_MAX < 1) begin : g_bad_sr
      $error("flash_wren_ctrl: SR_DATA_MAX must be at least 1");
   end
   if (OPC_WREN == OPC_VWREN || OPC_WREN == OPC_SRWR || OPC_VWREN == OPC_SRWR) begin : g_bad_opc
      $error("flash_wren_ctrl: opcodes must be distinct");
   end

   logic [2:0] line_s;
   logic       frame_end;
   logic [OPC_W-1:0] opc;
   logic [CNT_W-1:0] cnt;
   logic       wel;

   fw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({spi_cs_n, spi_sclk, spi_sdi}),
      .sync_o  (line_s)
   );

   fw_shifter #(.OPC_W(OPC_W), .CNT_SAT(CNT_SAT)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_s      (line_s[2]),
      .sclk_s      (line_s[1]),
      .sdi_s       (line_s[0]),
      .frame_end_o (frame_end),
      .opc_o       (opc),
      .cnt_o       (cnt)
   );

   fw_decode #(
      .OPC_W(OPC_W), .MAX_BITS(MAX_BITS), .CNT_W(CNT_W),
      .OPC_WREN(OPC_WREN), .OPC_VWREN(OPC_VWREN), .OPC_SRWR(OPC_SRWR)
   ) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_end_i (frame_end),
      .opc_i       (opc),
      .cnt_i       (cnt),
      .wel_clr_i   (wel_clr_i),
      .wel_o       (wel),
      .vflag_o     (vol_wr_en_o),
      .sr_vol_o    (sr_wr_vol_o),
      .sr_nv_o     (sr_wr_nv_o)
   );

   assign wel_o          = wel;
   assign allow_modify_o = wel;
   assign spi_do_oe_o    = 1'b0;

   AST_CS_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_s[2] && !wel_clr_i) |=> $stable(wel)); // R2

endmodule

// File: tb/flash_wren_ctrl_tb.sv
module flash_wren_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, wclr = 1'b0;
   logic wel, allow, vflag, svol, snv, doe;

   int checks = 0;
   int errors = 0;
   int vol_cnt = 0;
   int nv_cnt = 0;
   logic doe_seen = 1'b0;
   logic alias_bad = 1'b0;

   always #2 clk = ~clk;

   flash_wren_ctrl #(.SYNC_STAGES(3), .SR_DATA_MAX(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
      .wel_clr_i(wclr), .wel_o(wel), .allow_modify_o(allow), .vol_wr_en_o(vflag),
      .sr_wr_vol_o(svol), .sr_wr_nv_o(snv), .spi_do_oe_o(doe)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (svol) vol_cnt++;
         if (snv)  nv_cnt++;
         if (doe)  doe_seen = 1'b1;
         if (allow !== wel) alias_bad = 1'b1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // mode3: clock idles high; raise: end frame with chip select high
   task automatic frame(input logic [31:0] bits, input int n, input bit mode3, input bit raise = 1'b1);
      sclk = mode3;
      tick(4);
      cs_n = 1'b0;
      tick(4);
      for (int i = n - 1; i >= 0; i--) begin
         sclk = 1'b0;
         sdi  = bits[i];
         tick(4);
         sclk = 1'b1;
         tick(4);
      end
      if (!mode3) sclk = 1'b0;
      tick(4);
      if (raise) begin
         cs_n = 1'b1;
         tick(12);
      end
   endtask

   task automatic pulse_clear();
      wclr = 1'b1;
      tick(1);
      wclr = 1'b0;
      tick(2);
   endtask

   task automatic t_reset();
      chk("R1 wel", wel, 0);
      chk("R1 allow", allow, 0);
      chk("R1 vflag", vflag, 0);
      chk("R1 pulses", {svol, snv}, 0);
   endtask

   task automatic t_wren_mode0();
      frame(32'h06, 8, 1'b0, 1'b0);
      chk("R2 latch before cs high", wel, 0);
      cs_n = 1'b1;
      tick(12);
      chk("R2 R4 mode0 latch set", wel, 1);
      chk("R10 allow follows", allow, 1);
   endtask

   task automatic t_clear_and_mode3();
      pulse_clear();
      chk("R6 latch cleared", wel, 0);
      chk("R10 allow cleared", allow, 0);
      frame(32'h06, 8, 1'b1);
      chk("R4 mode3 latch set", wel, 1);
   endtask

   task automatic t_vwren();
      frame(32'h50, 8, 1'b1);
      chk("R3 flag set", vflag, 1);
      chk("R3 latch kept 1", wel, 1);
      pulse_clear();
      frame(32'h50, 8, 1'b0);
      chk("R3 latch kept 0", wel, 0);
      chk("R3 flag set again", vflag, 1);
   endtask

   task automatic t_sr_volatile();
      int v0 = vol_cnt, n0 = nv_cnt;
      frame(32'h01A5, 16, 1'b0);
      chk("R7 one volatile start", vol_cnt - v0, 1);
      chk("R7 no nv start", nv_cnt - n0, 0);
      chk("R7 flag consumed", vflag, 0);
   endtask

   task automatic t_sr_nonvol();
      int v0, n0;
      frame(32'h06, 8, 1'b1);
      v0 = vol_cnt; n0 = nv_cnt;
      frame(32'h01_3C_C3, 24, 1'b1);
      chk("R8 nv start", nv_cnt - n0, 1);
      chk("R8 no volatile start", vol_cnt - v0, 0);
      pulse_clear();
      v0 = vol_cnt; n0 = nv_cnt;
      frame(32'h0100, 16, 1'b0);
      chk("R8 no start without latch", (nv_cnt - n0) + (vol_cnt - v0), 0);
   endtask

   task automatic t_bad_counts();
      int v0, n0;
      frame(32'h03, 7, 1'b0);
      chk("R5 seven clocks ignored", wel, 0);
      frame(32'h00C, 9, 1'b1);
      chk("R5 nine clocks ignored", wel, 0);
      frame(32'h0A0, 9, 1'b0);
      chk("R5 long 0x50 ignored", vflag, 0);
      frame(32'h50, 8, 1'b0);
      v0 = vol_cnt; n0 = nv_cnt;
      frame(32'h01F, 12, 1'b1);
      chk("R5 twelve-clock status write ignored", {vflag, 8'(vol_cnt - v0 + nv_cnt - n0)}, 9'h100);
      frame(32'h01_11_22_33, 32, 1'b0);
      chk("R5 over-long status write ignored", {vflag, 8'(vol_cnt - v0 + nv_cnt - n0)}, 9'h100);
      sclk = 1'b0;
      for (int i = 0; i < 6; i++) begin
         sclk = ~sclk;
         tick(4);
      end
      chk("R5 idle clock edges ignored", {wel, vflag}, 2'b01);
   endtask

   task automatic t_other_clears();
      frame(32'h9F, 8, 1'b1);
      chk("R9 other opcode clears flag", vflag, 0);
      chk("R9 latch untouched", wel, 0);
      frame(32'h50, 8, 1'b0);
      frame(32'h06, 8, 1'b0);
      chk("R9 0x06 clears flag", vflag, 0);
      chk("R9 0x06 sets latch", wel, 1);
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_wren_mode0();
      t_clear_and_mode3();
      t_vwren();
      t_sr_volatile();
      t_sr_nonvol();
      t_bad_counts();
      t_other_clears();
      chk("R10 output enable never high", doe_seen, 0);
      chk("R10 allow always equals latch", alias_bad, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule